// File: doc/BRIEF.md
# Program Counter and Exception Entry Unit

This block holds the program counter of a simple 32-bit single-issue RISC core and decides, every cycle, where the next fetch comes from. The three possible sources are the sequential address (PC+4), a branch or jump target supplied by the datapath, and a fixed exception vector. It also owns the processor's privilege mode.

Exception entry works like a procedure call that the hardware forces. The decoder may flag the current instruction as an illegal opcode. That is a synchronous event, and it vectors to 0x4. An I/O interrupt request is an asynchronous event, and it vectors to 0x8. When either one is taken, the unit cancels the instruction's own effects. Memory write is held off, and the register-file write port is taken over so that PC+4 is written into general register 30, the exception pointer. Entry also switches the core into supervisor mode. Interrupt requests are ignored in supervisor mode, so the saved pointer cannot be clobbered while a handler runs.

The privilege mode is a two-state machine with the states `MODE_SUPER` and `MODE_USER`. Reset places the machine in `MODE_SUPER`.
- The transition `ENTER` (any state to `MODE_SUPER`) fires whenever an exception is taken.
- The transition `DROP` (`MODE_SUPER` to `MODE_USER`) fires on a taken branch, with no exception in that cycle, whose target has bit 31 clear.
- Every other cycle is a `HOLD` transition and keeps the state.

A taken branch made in user mode can never raise the privilege. Fetch addresses always have bit 31 and bits 1:0 cleared.

Top module: `pcx_pc_unit`

## Requirements
- R1: After reset the PC reads 0x00000000 and the supervisor output is 1.
- R2: With no exception and no taken branch, the PC advances by 4 on each clock.
- R3: With no exception and a taken branch, the next PC is the target with bit 31 and bits 1:0 forced to 0.
- R4: An illegal-opcode flag loads the PC with 0x00000004 on the next clock, whatever the interrupt, mode and branch inputs are; it has priority over an interrupt in the same cycle.
- R5: An interrupt request in user mode, with no illegal opcode, loads the PC with 0x00000008 on the next clock and overrides any taken branch.
- R6: In supervisor mode an interrupt request is ignored: no exception is signalled, the register and memory write controls pass through, and the PC follows the sequential or branch path.
- R7: In an exception cycle, exc_o is 1, the register write enable is 1, the write address is 30, the write data is the current PC+4, and the memory write enable is 0.
- R8: Outside exception cycles, exc_o is 0 and the register write enable, write address, write data and memory write enable equal their decoder inputs.
- R9: After any taken exception, the supervisor output is 1.
- R10: In supervisor mode, a taken branch without an exception clears the supervisor output when target bit 31 is 0 and keeps it set when bit 31 is 1; in user mode, no branch sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| illop_i | input | 1 | Decoder flags the current instruction as an illegal opcode |
| irq_i | input | 1 | Pending external interrupt request |
| br_taken_i | input | 1 | Current instruction redirects fetch |
| br_target_i | input | 32 | Redirect target; bit 31 requests user mode when 0 |
| dec_rf_we_i | input | 1 | Decoder register write enable |
| dec_rf_wa_i | input | 5 | Decoder register write address |
| dec_rf_wd_i | input | 32 | Datapath register write data |
| dec_mem_we_i | input | 1 | Decoder memory write enable |
| pc_o | output | 32 | Current program counter |
| super_o | output | 1 | Supervisor mode |
| exc_o | output | 1 | Exception taken this cycle |
| rf_we_o | output | 1 | Register write enable to the register file |
| rf_wa_o | output | 5 | Register write address |
| rf_wd_o | output | 32 | Register write data |
| mem_we_o | output | 1 | Memory write enable |

## Verification
An illegal opcode, an interrupt request and a taken branch can all fall in the same cycle. The priority among them decides both the next PC and the state of the write port. The bench drives these inputs with independent random probabilities, so coincidences happen often. It also forces the worst case directly: all three at once in user mode, and an interrupt together with a branch in supervisor mode. Each cycle is judged against a bench model. The model checks the write controls before the clock edge, and the PC and mode after it.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    typedef enum logic {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_SYNC  = 2'd1,
        CAUSE_ASYNC = 2'd2
    } cause_e;

endpackage

// File: rtl/pcx_exc_arb.sv
module pcx_exc_arb
    import pcx_pkg::*;
(
    input  logic   illop_i,
    input  logic   irq_i,
    input  logic   super_i,
    output cause_e cause_o
);

    // Synchronous fault outranks an interrupt; interrupts are masked in supervisor mode.
    always_comb begin
        if (illop_i)
            cause_o = CAUSE_SYNC;
        else if (irq_i && !super_i)
            cause_o = CAUSE_ASYNC;
        else
            cause_o = CAUSE_NONE;
    end

endmodule

// File: rtl/pcx_mode_fsm.sv
module pcx_mode_fsm
    import pcx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_e cause_i,
    input  logic   br_taken_i,
    input  logic   br_tgt_msb_i,
    output mode_e  mode_o
);

    mode_e state_q, state_d;

    // Next-state process.
    always_comb begin
        state_d = state_q;
        if (cause_i != CAUSE_NONE) begin
            state_d = MODE_SUPER;                       // ENTER
        end else begin
            unique case (state_q)
                MODE_SUPER: begin
                    if (br_taken_i && !br_tgt_msb_i)
                        state_d = MODE_USER;            // DROP
                end
                MODE_USER: state_d = MODE_USER;         // HOLD
                default:   state_d = MODE_SUPER;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= MODE_SUPER;
        else
            state_q <= state_d;
    end

    assign mode_o = state_q;

    // R9
    enter_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_i != CAUSE_NONE) |=> (state_q == MODE_SUPER));

    // R10
    no_user_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_USER && cause_i == CAUSE_NONE) |=> (state_q == MODE_USER));

endmodule

// File: rtl/pcx_wb_ctrl.sv
module pcx_wb_ctrl #(
    parameter int XLEN   = 32,
    parameter int RA_W   = 5,
    parameter int XP_IDX = 30
) (
    input  logic            take_i,
    input  logic [XLEN-1:0] ret_addr_i,
    input  logic            dec_rf_we_i,
    input  logic [RA_W-1:0] dec_rf_wa_i,
    input  logic [XLEN-1:0] dec_rf_wd_i,
    input  logic            dec_mem_we_i,
    output logic            rf_we_o,
    output logic [RA_W-1:0] rf_wa_o,
    output logic [XLEN-1:0] rf_wd_o,
    output logic            mem_we_o
);

    localparam logic [RA_W-1:0] XP_ADDR = RA_W'(XP_IDX);

    always_comb begin
        if (take_i) begin
            rf_we_o  = 1'b1;
            rf_wa_o  = XP_ADDR;
            rf_wd_o  = ret_addr_i;
            mem_we_o = 1'b0;
        end else begin
            rf_we_o  = dec_rf_we_i;
            rf_wa_o  = dec_rf_wa_i;
            rf_wd_o  = dec_rf_wd_i;
            mem_we_o = dec_mem_we_i;
        end
    end

endmodule

// File: rtl/pcx_pc_unit.sv
module pcx_pc_unit
    import pcx_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int RA_W      = 5,
    parameter int XP_IDX    = 30,
    parameter int SYNC_VEC  = 4,
    parameter int ASYNC_VEC = 8,
    parameter int RESET_PC  = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            illop_i,
    input  logic            irq_i,
    input  logic            br_taken_i,
    input  logic [XLEN-1:0] br_target_i,
    input  logic            dec_rf_we_i,
    input  logic [RA_W-1:0] dec_rf_wa_i,
    input  logic [XLEN-1:0] dec_rf_wd_i,
    input  logic            dec_mem_we_i,
    output logic [XLEN-1:0] pc_o,
    output logic            super_o,
    output logic            exc_o,
    output logic            rf_we_o,
    output logic [RA_W-1:0] rf_wa_o,
    output logic [XLEN-1:0] rf_wd_o,
    output logic            mem_we_o
);

    localparam logic [XLEN-1:0] ADDR_MASK = {1'b0, {(XLEN-3){1'b1}}, 2'b00};
    localparam logic [XLEN-1:0] V_SYNC    = XLEN'(SYNC_VEC);
    localparam logic [XLEN-1:0] V_ASYNC   = XLEN'(ASYNC_VEC);
    localparam logic [XLEN-1:0] V_RESET   = XLEN'(RESET_PC);

    logic [XLEN-1:0] pc_q, pc_d, pc_inc;
    cause_e          cause;
    mode_e           mode;

    assign pc_inc = pc_q + XLEN'(4);

    pcx_exc_arb u_arb (
        .illop_i (illop_i),
        .irq_i   (irq_i),
        .super_i (mode == MODE_SUPER),
        .cause_o (cause)
    );

    pcx_mode_fsm u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .cause_i      (cause),
        .br_taken_i   (br_taken_i),
        .br_tgt_msb_i (br_target_i[XLEN-1]),
        .mode_o       (mode)
    );

    pcx_wb_ctrl #(.XLEN(XLEN), .RA_W(RA_W), .XP_IDX(XP_IDX)) u_wb (
        .take_i       (cause != CAUSE_NONE),
        .ret_addr_i   (pc_inc),
        .dec_rf_we_i  (dec_rf_we_i),
        .dec_rf_wa_i  (dec_rf_wa_i),
        .dec_rf_wd_i  (dec_rf_wd_i),
        .dec_mem_we_i (dec_mem_we_i),
        .rf_we_o      (rf_we_o),
        .rf_wa_o      (rf_wa_o),
        .rf_wd_o      (rf_wd_o),
        .mem_we_o     (mem_we_o)
    );

    // Next fetch address selection.
    always_comb begin
        unique case (cause)
            CAUSE_SYNC:  pc_d = V_SYNC;
            CAUSE_ASYNC: pc_d = V_ASYNC;
            default:     pc_d = br_taken_i ? (br_target_i & ADDR_MASK) : pc_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= V_RESET;
        else
            pc_q <= pc_d;
    end

    assign pc_o    = pc_q;
    assign super_o = (mode == MODE_SUPER);
    assign exc_o   = (cause != CAUSE_NONE);

    // R4
    sync_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illop_i |=> (pc_q == V_SYNC));

    // R5
    async_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && !illop_i && !super_o) |=> (pc_q == V_ASYNC));

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (super_o && irq_i && !illop_i) |-> !exc_o);

    // R7
    xp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (rf_we_o && rf_wa_o == RA_W'(XP_IDX) && !mem_we_o && rf_wd_o == pc_o + XLEN'(4)));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!illop_i && !irq_i && !br_taken_i) |=> (pc_q == $past(pc_q) + XLEN'(4)));

endmodule

// File: tb/tb_pcx_pc_unit.sv
module tb_pcx_pc_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        illop_i, irq_i, br_taken_i;
    logic [31:0] br_target_i;
    logic        dec_rf_we_i;
    logic [4:0]  dec_rf_wa_i;
    logic [31:0] dec_rf_wd_i;
    logic        dec_mem_we_i;
    logic [31:0] pc_o;
    logic        super_o, exc_o, rf_we_o, mem_we_o;
    logic [4:0]  rf_wa_o;
    logic [31:0] rf_wd_o;

    int n_vec = 0;
    int n_bad = 0;
    logic        m_super;
    logic [31:0] m_pc;
    string       pc_tag;
    bit          done = 0;

    always #5 clk = ~clk;

    pcx_pc_unit dut (
        .clk(clk), .rst_n(rst_n), .illop_i(illop_i), .irq_i(irq_i),
        .br_taken_i(br_taken_i), .br_target_i(br_target_i),
        .dec_rf_we_i(dec_rf_we_i), .dec_rf_wa_i(dec_rf_wa_i),
        .dec_rf_wd_i(dec_rf_wd_i), .dec_mem_we_i(dec_mem_we_i),
        .pc_o(pc_o), .super_o(super_o), .exc_o(exc_o), .rf_we_o(rf_we_o),
        .rf_wa_o(rf_wa_o), .rf_wd_o(rf_wd_o), .mem_we_o(mem_we_o)
    );

    function automatic logic f_exc(logic il, logic iq, logic sup);
        return il || (iq && !sup);
    endfunction

    function automatic logic [31:0] f_next_pc(logic [31:0] pc, logic sup, logic il,
                                              logic iq, logic br, logic [31:0] tgt);
        if (il) return 32'h4;
        if (iq && !sup) return 32'h8;
        if (br) return {1'b0, tgt[30:2], 2'b00};
        return pc + 32'd4;
    endfunction

    function automatic logic f_next_sup(logic sup, logic il, logic iq, logic br, logic [31:0] tgt);
        if (f_exc(il, iq, sup)) return 1'b1;
        if (sup && br && !tgt[31]) return 1'b0;
        return sup;
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check write controls, then let the clock rise.
    task automatic step(logic il, logic iq, logic br, logic [31:0] tgt);
        string t;
        logic  e;
        illop_i = il; irq_i = iq; br_taken_i = br; br_target_i = tgt;
        dec_rf_we_i = 1'($urandom); dec_rf_wa_i = 5'($urandom);
        dec_rf_wd_i = $urandom; dec_mem_we_i = 1'($urandom);
        #1;
        e = f_exc(il, iq, m_super);
        if (e) begin
            chk("R7", "exc", {63'd0, exc_o}, 64'd1);
            chk("R7", "rf_we", {63'd0, rf_we_o}, 64'd1);
            chk("R7", "rf_wa", {59'd0, rf_wa_o}, 64'd30);
            chk("R7", "rf_wd", {32'd0, rf_wd_o}, {32'd0, m_pc + 32'd4});
            chk("R7", "mem_we", {63'd0, mem_we_o}, 64'd0);
        end else begin
            t = (m_super && iq) ? "R6" : "R8";
            chk(t, "exc", {63'd0, exc_o}, 64'd0);
            chk(t, "wb", {25'd0, rf_we_o, rf_wa_o, rf_wd_o, mem_we_o},
                {25'd0, dec_rf_we_i, dec_rf_wa_i, dec_rf_wd_i, dec_mem_we_i});
        end
        if (il) pc_tag = "R4";
        else if (e) pc_tag = "R5";
        else if (m_super && iq) pc_tag = "R6";
        else if (br) pc_tag = "R3";
        else pc_tag = "R2";
        t = e ? "R9" : "R10";
        m_pc    = f_next_pc(m_pc, m_super, il, iq, br, tgt);
        m_super = f_next_sup(m_super, il, iq, br, tgt);
        @(negedge clk);
        chk(pc_tag, "pc", {32'd0, pc_o}, {32'd0, m_pc});
        chk(t, "super", {63'd0, super_o}, {63'd0, m_super});
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        illop_i = 0; irq_i = 0; br_taken_i = 0; br_target_i = 0;
        dec_rf_we_i = 0; dec_rf_wa_i = 0; dec_rf_wd_i = 0; dec_mem_we_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_pc = 32'h0; m_super = 1'b1;
        chk("R1", "pc", {32'd0, pc_o}, 64'd0);
        chk("R1", "super", {63'd0, super_o}, 64'd1);
        // Directed corners.
        step(0, 1, 1, 32'h8000_1003);   // R6 masked irq with branch, stays super (R10)
        step(0, 0, 0, 32'h0);           // R2
        step(0, 0, 1, 32'h0000_0107);   // R10 drop to user, R3 masking
        step(0, 0, 1, 32'hFFFF_FFFF);   // R10 user cannot raise
        step(1, 1, 1, 32'h0000_0200);   // R4 all three at once in user
        step(0, 0, 1, 32'h0000_0300);   // leave super again
        step(0, 1, 1, 32'h0000_0400);   // R5 irq beats branch
        step(0, 1, 0, 32'h0);           // R6 in super after entry
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 8) == 0, ($urandom % 4) == 0,
                 ($urandom % 3) == 0, $urandom);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule